// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog timer with a small word-addressed register bus. It counts down from a software-chosen reload value. Software starts it by turning on the enable bit in the control word. It keeps the system alive by writing a 16-bit key to the restart word. If the count runs out, the block performs the timeout actions that control enables: a system reset pulse that carries a reset-scope flag, an interrupt level, and an external pulse. After that it stops.

The count can advance on every clock or once per prescaler period. The prescaler period is a parameter and defaults to 24 clocks, which gives a 1 µs tick from a 24 MHz clock. The enable bit acts on edges. A control write is taken only when it changes the enable state, so the timeout actions cannot be changed while the counter runs.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the count word and the reload word both read 0x03EF1480, the control word reads 0, and the outputs `sys_rst_pulse`, `sys_rst_full`, `irq` and `ext_pulse` are low.
- R2: Word address 0 returns the live count and ignores writes. Address 1 is the reload value and can be written and read back. Address 2 always reads 0. Address 3 is control. The read data shows up on the cycle after the read is presented.
- R3: A write to address 2 whose bits 15:0 equal 0x4755 loads the count from the reload word, whatever the upper bits hold. Any other value leaves the count unchanged.
- R4: A control write with bit 0 (enable) set, made while disabled, stores the whole word and loads the count from reload. The count then decrements.
- R5: A control write with bit 0 clear, made while enabled, stores the word and freezes the count.
- R6: A control write whose bit 0 equals the current enable state is ignored, and the control word keeps its old value.
- R7: With control bit 4 clear, the count drops by one on every clock.
- R8: With control bit 4 set, the count drops by one every DIV clocks. The prescaler restarts at every load, so the first decrement comes DIV clocks after the load.
- R9: When the count reaches zero while enabled, the block acts once, on the second clock after the final decrement. If control bit 1 is set, `sys_rst_pulse` is high for one cycle, and during that cycle `sys_rst_full` equals control bit 5. If control bit 3 is set, `ext_pulse` is high for one cycle. The count then stays at zero.
- R10: If control bit 2 is set at expiry, `irq` rises and stays high until a keyed restart or a control write that changes the enable state.
- R11: Word addresses 4 and above read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, which is also the fast tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sys_rst_pulse | output | 1 | One-cycle system reset request on timeout |
| sys_rst_full | output | 1 | Reset scope during the pulse (1 = whole chip) |
| irq | output | 1 | Timeout interrupt level |
| ext_pulse | output | 1 | One-cycle external timeout signal |

## Verification
The hardest situation to reach is a control write made while the counter runs that changes every action bit but leaves enable set. The write must be dropped, so the stimulus enables the counter with a large reload, issues such a write, and then reads the control word back. The slow-tick path needs the prescaler phase to be exact. The stimulus therefore reads the count on the clock after the load and again exactly DIV clocks later, and expects the values to differ by one. Expiry timing is checked by counting clocks from the enabling write to the first pulse.

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int          ADDR_W      = 4,
  parameter int          DIV         = 24,
  parameter logic [31:0] RESET_COUNT = 32'h03EF1480,
  parameter logic [15:0] KEY         = 16'h4755
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sys_rst_pulse,
  output logic              sys_rst_full,
  output logic              irq,
  output logic              ext_pulse
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_REL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(3);
  localparam logic [PW-1:0]     P_TOP = PW'(DIV - 1);

  logic [31:0]   cnt_q, rel_q, ctrl_q, rd_mux;
  logic [PW-1:0] pre_q;
  logic          done_q;

  wire wr      = bus_sel & bus_we;
  wire rd      = bus_sel & ~bus_we;
  wire restart = wr && bus_addr == A_KEY && bus_wdata[15:0] == KEY;
  wire ctl_wr  = wr && bus_addr == A_CTL && bus_wdata[0] != ctrl_q[0];
  wire en_on   = ctl_wr & bus_wdata[0];
  wire en_off  = ctl_wr & ~bus_wdata[0];
  wire load    = restart | en_on;
  wire live    = ctrl_q[0] & ~done_q;
  wire tick    = ~ctrl_q[4] | (pre_q == P_TOP);
  wire fire    = live && cnt_q == 32'd0;

  always_comb begin
    case (bus_addr)
      A_CNT:   rd_mux = cnt_q;
      A_REL:   rd_mux = rel_q;
      A_CTL:   rd_mux = ctrl_q;
      default: rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q         <= RESET_COUNT;
      rel_q         <= RESET_COUNT;
      ctrl_q        <= 32'd0;
      pre_q         <= '0;
      done_q        <= 1'b0;
      bus_rdata     <= 32'd0;
      sys_rst_pulse <= 1'b0;
      sys_rst_full  <= 1'b0;
      irq           <= 1'b0;
      ext_pulse     <= 1'b0;
    end else begin
      if (wr && bus_addr == A_REL) rel_q <= bus_wdata;
      if (ctl_wr) ctrl_q <= bus_wdata;

      if (load) begin
        cnt_q  <= rel_q;
        pre_q  <= '0;
        done_q <= 1'b0;
      end else begin
        if (live) pre_q <= (pre_q == P_TOP) ? '0 : pre_q + 1'b1;
        if (live && cnt_q != 32'd0 && tick) cnt_q <= cnt_q - 32'd1;
        if (fire) done_q <= 1'b1;
      end

      sys_rst_pulse <= fire & ctrl_q[1];
      sys_rst_full  <= fire & ctrl_q[1] & ctrl_q[5];
      ext_pulse     <= fire & ctrl_q[3];
      if (restart | ctl_wr)          irq <= 1'b0;
      else if (fire & ctrl_q[2])     irq <= 1'b1;

      bus_rdata <= rd ? rd_mux : 32'd0;
    end
  end
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(parameter int ADDR_W = 4) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       cnt_q,
  input logic [31:0]       ctrl_q,
  input logic              load,
  input logic              sys_rst_pulse,
  input logic              sys_rst_full,
  input logic              irq,
  input logic              ext_pulse
);
  assert_rst_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |=> !sys_rst_pulse);
  assert_ext_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_pulse |=> !ext_pulse);
  assert_rst_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |-> $past(ctrl_q[1]));
  assert_scope_in_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_full |-> sys_rst_pulse);
  assert_irq_clear_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_sel && bus_we && (bus_addr == ADDR_W'(2) || bus_addr == ADDR_W'(3))));
  assert_rise_only_on_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > $past(cnt_q)) |-> $past(load));
  assert_same_enable_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == ADDR_W'(3) && bus_wdata[0] == ctrl_q[0]) |=> $stable(ctrl_q));
  assert_frozen_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[0] && !load) |=> $stable(cnt_q));
endmodule

bind wdog_keyed wdog_keyed_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_q(cnt_q), .ctrl_q(ctrl_q),
  .load(load), .sys_rst_pulse(sys_rst_pulse), .sys_rst_full(sys_rst_full),
  .irq(irq), .ext_pulse(ext_pulse));

// File: tb/sim_wdog_keyed.sv
module sim_wdog_keyed;
  localparam int DIV = 24;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sys_rst_pulse, sys_rst_full, irq, ext_pulse;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  wdog_keyed #(.DIV(DIV)) u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic watch(int n, output int rc, output int rfirst, output logic rfull,
                       output int ec, output int efirst);
    rc = 0; rfirst = -1; rfull = 0; ec = 0; efirst = -1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (sys_rst_pulse) begin rc++; if (rfirst < 0) begin rfirst = i; rfull = sys_rst_full; end end
      if (ext_pulse) begin ec++; if (efirst < 0) efirst = i; end
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'd0, d); chk("R1 count", d, 32'h03EF1480);
    rd(4'd1, d); chk("R1 reload", d, 32'h03EF1480);
    rd(4'd3, d); chk("R1 control", d, 32'h0);
    chk("R1 outputs", {sys_rst_pulse, sys_rst_full, irq, ext_pulse}, 32'h0);
    rd(4'd2, d); chk("R2 restart reads zero", d, 32'h0);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    wr(4'd1, 32'h0000_1234);
    rd(4'd1, d); chk("R2 reload readback", d, 32'h1234);
    wr(4'd0, 32'h7);
    rd(4'd0, d); chk("R2 count write ignored", d, 32'h03EF1480);
    wr(4'd2, 32'h0000_4756);
    rd(4'd0, d); chk("R3 bad key ignored", d, 32'h03EF1480);
    wr(4'd2, 32'hABCD_4755);
    rd(4'd0, d); chk("R3 good key reloads", d, 32'h1234);
    for (int a = 4; a < 16; a++) wr(a[3:0], 32'hFFFF_FFFF);
    rd(4'd1, d); chk("R11 reload untouched", d, 32'h1234);
    rd(4'd3, d); chk("R11 control untouched", d, 32'h0);
    rd(4'd0, d); chk("R11 count untouched", d, 32'h1234);
    rd(4'd5, d); chk("R11 unmapped reads zero", d, 32'h0);
    rd(4'd12, d); chk("R11 high unmapped reads zero", d, 32'h0);
  endtask

  task automatic t_ctrl_edge;
    logic [31:0] d, e;
    wr(4'd3, 32'h10);
    rd(4'd3, d); chk("R6 write while off with enable clear", d, 32'h0);
    wr(4'd1, 32'd100);
    wr(4'd3, 32'h1);
    rd(4'd0, d); rd(4'd0, e);
    chk("R4 loaded on enable", d, 32'd100);
    chk("R7 one per clock", e, 32'd99);
    wr(4'd3, 32'h3F);
    rd(4'd3, d); chk("R6 running write ignored", d, 32'h1);
    wr(4'd3, 32'h20);
    rd(4'd3, d); chk("R5 control stored on disable", d, 32'h20);
    rd(4'd0, d); idle(5); rd(4'd0, e);
    chk("R5 count frozen", e, d);
  endtask

  task automatic t_slow;
    logic [31:0] d;
    int rc, rf, ec, ef; logic full;
    wr(4'd1, 32'd3);
    wr(4'd3, 32'h11);
    rd(4'd0, d); chk("R8 initial value held", d, 32'd3);
    idle(DIV - 2);
    rd(4'd0, d); chk("R8 no decrement before DIV clocks", d, 32'd3);
    rd(4'd0, d); chk("R8 decrement after DIV clocks", d, 32'd2);
    watch(3 * DIV, rc, rf, full, ec, ef);
    rd(4'd0, d); chk("R9 count stays zero", d, 32'd0);
    chk("R9 no pulses when actions off", rc + ec, 0);
    chk("R10 no irq when bit 2 clear", irq, 0);
    wr(4'd3, 32'h0);
  endtask

  task automatic t_expire;
    logic [31:0] d;
    int rc, rf, ec, ef; logic full;
    wr(4'd1, 32'd5);
    wr(4'd3, 32'h2F);
    watch(20, rc, rf, full, ec, ef);
    chk("R9 single reset pulse", rc, 1);
    chk("R9 reset pulse cycle", rf, 6);
    chk("R9 full-chip scope", full, 1);
    chk("R9 single ext pulse", ec, 1);
    chk("R9 ext pulse cycle", ef, 6);
    chk("R10 irq raised", irq, 1);
    rd(4'd0, d); chk("R9 stopped at zero", d, 0);
    wr(4'd2, 32'h0000_1111);
    chk("R10 irq held on bad key", irq, 1);
    wr(4'd2, 32'h0000_4755);
    chk("R10 irq cleared by restart", irq, 0);
    wr(4'd3, 32'h0);
    wr(4'd1, 32'd2);
    wr(4'd3, 32'h07);
    watch(10, rc, rf, full, ec, ef);
    chk("R9 reset pulse count", rc, 1);
    chk("R9 soc-only scope", full, 0);
    chk("R9 ext off", ec, 0);
    chk("R10 irq raised again", irq, 1);
    wr(4'd3, 32'h0);
    chk("R10 irq cleared by disable", irq, 0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_regmap;
    t_ctrl_edge;
    t_slow;
    t_expire;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule